// File: doc/BRIEF.md
# Warp Issue Scheduler

This block sits in front of a group of SIMD lanes and decides, once per issue slot, which resident warp sends its next instruction. The chosen instruction goes to every lane of that warp together. A warp can compete only when three things hold: it has a decoded instruction waiting, the operand-ready input for it is high, and it has no long-latency load outstanding. Among the warps that can compete, a rotating pointer gives priority to the warp just after the one that issued last. This means no warp that stays eligible is passed over for ever.

Each issue holds the lanes for a fixed number of cycles (four by default). The next issue can start in the cycle right after that window ends, and it may come from a different warp at no extra cost. When a warp issues a long-latency load, the block records it in a small per-warp scoreboard. That warp is then left out of selection until a return strobe arrives carrying its ID. When the slot is free and no warp can go, the block raises a stall output and issues nothing.

Instruction fetch, decode, the lane datapath and memory are outside the block. They talk to it only through the valid, load-marker, ready and return signals.

Top module: `warp_issue_sched`

## Requirements
- R1: A warp is issued only if, in the cycle the decision is made, its `inst_valid` bit is 1, its `opnd_rdy` bit is 1 and it has no outstanding load.
- R2: `issue_o` is a pulse one cycle long. `busy_o` is 1 for exactly ISSUE_CYCLES cycles, starting with the cycle of the pulse. No second pulse comes within ISSUE_CYCLES cycles of the previous one.
- R3: While warps stay eligible, issue pulses arrive exactly ISSUE_CYCLES cycles apart, even when consecutive issues come from different warps.
- R4: Priority rotates. The search starts at the warp ID one above the last issued ID and wraps from NUM_WARPS-1 to 0. After reset, warp 0 has the highest priority.
- R5: Issuing a warp whose `inst_is_load` bit is 1 marks that warp as waiting. It is not issued again until a cycle with `ld_ret_valid`=1 and `ld_ret_warp` equal to its ID. It becomes eligible in the cycle after that return. A return carrying another ID leaves it blocked.
- R6: `stall_o` is 1 exactly when the issue slot is free and no warp is eligible. In such a cycle no issue starts. While the slot is held, `stall_o` is 0.
- R7: During and right after reset: `issue_o`=0, `busy_o`=0, `issue_warp_o`=0, and no warp is waiting on a load.
- R8: `issue_warp_o` carries the ID of the issued warp from the pulse cycle onwards and keeps it until the next issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| inst_valid | input | NUM_WARPS | Per warp: a decoded next instruction is waiting |
| inst_is_load | input | NUM_WARPS | Per warp: the waiting instruction is a long-latency load |
| opnd_rdy | input | NUM_WARPS | Per warp: operands of the waiting instruction are ready |
| ld_ret_valid | input | 1 | Load data has returned for one warp this cycle |
| ld_ret_warp | input | WID_W | ID of the warp whose load returned |
| issue_o | output | 1 | One-cycle strobe: an issue starts |
| issue_warp_o | output | WID_W | ID of the warp most recently issued |
| busy_o | output | 1 | Lanes are occupied by the current issue |
| stall_o | output | 1 | Slot free but no warp eligible |

## Verification
The bench builds the block with its default values: 16 warps, so WID_W is 4, and a 4-cycle issue window. With 16 warps, a run of 18 consecutive issues carries the rotating pointer across the wrap from 15 back to 0 and into a second lap. The 4-cycle window leaves three middle cycles, in which the bench checks that `busy_o`, the held warp ID and the absence of a pulse all behave as required. The load case is checked with a single waiting warp. This shows that an unrelated return does not unblock it, and it fixes the exact cycle in which the matching return makes the warp eligible again.

// File: rtl/wis_pkg.sv
package wis_pkg;

    localparam int DEF_WARPS        = 16;
    localparam int DEF_ISSUE_CYCLES = 4;

    // Where the issue window stands: open (no issue in flight), in its
    // last cycle (a new issue may start at the coming edge), or held.
    typedef enum logic [1:0] {
        PH_OPEN = 2'd0,
        PH_LAST = 2'd1,
        PH_HELD = 2'd2
    } slot_phase_e;

    // base + off wrapped into 0..n-1, for base < n and off <= n
    function automatic int wrap_idx(int base, int off, int n);
        int s;
        s = base + off;
        if (s >= n) s = s - n;
        return s;
    endfunction

    function automatic int id_width(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/wis_scoreboard.sv
module wis_scoreboard
    import wis_pkg::*;
#(
    parameter int NW  = DEF_WARPS,
    parameter int IDW = id_width(NW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NW-1:0]  inst_valid,
    input  logic [NW-1:0]  opnd_rdy,
    input  logic           set_en,
    input  logic [IDW-1:0] set_id,
    input  logic           clr_en,
    input  logic [IDW-1:0] clr_id,
    output logic [NW-1:0]  eligible
);

    logic [NW-1:0] waiting;

    for (genvar w = 0; w < NW; w++) begin : g_warp
        always_ff @(posedge clk) begin
            if (rst) begin
                waiting[w] <= 1'b0;
            end else if (set_en && set_id == IDW'(w)) begin
                waiting[w] <= 1'b1;
            end else if (clr_en && clr_id == IDW'(w)) begin
                waiting[w] <= 1'b0;
            end
        end

        assign eligible[w] = inst_valid[w] & opnd_rdy[w] & ~waiting[w];

        // R5
        load_block_chk: assert property (@(posedge clk) disable iff (rst)
            (set_en && set_id == IDW'(w)) |=> !eligible[w]);
    end

endmodule

// File: rtl/wis_rr_pick.sv
module wis_rr_pick
    import wis_pkg::*;
#(
    parameter int NW  = DEF_WARPS,
    parameter int IDW = id_width(NW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NW-1:0]  req,
    input  logic           take,
    output logic           grant_valid,
    output logic [IDW-1:0] grant_id
);

    logic [IDW-1:0] last_id;
    logic [IDW-1:0] cand;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_id <= IDW'(NW - 1);
        end else if (take) begin
            last_id <= grant_id;
        end
    end

    always_comb begin
        grant_valid = 1'b0;
        grant_id    = '0;
        cand        = '0;
        for (int k = 1; k <= NW; k++) begin
            cand = IDW'(wrap_idx(int'(last_id), k, NW));
            if (!grant_valid && req[cand]) begin
                grant_valid = 1'b1;
                grant_id    = cand;
            end
        end
    end

    // R4
    grant_req_chk: assert property (@(posedge clk) disable iff (rst)
        (req != '0) |-> grant_valid);

endmodule

// File: rtl/wis_slot_timer.sv
module wis_slot_timer
    import wis_pkg::*;
#(
    parameter int ISSUE_CYCLES = DEF_ISSUE_CYCLES,
    parameter int CW           = $clog2(ISSUE_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic slot_free,
    output logic busy
);

    logic [CW-1:0] remain;
    slot_phase_e   phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (start) begin
            remain <= CW'(ISSUE_CYCLES);
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    always_comb begin
        if (remain == '0)           phase = PH_OPEN;
        else if (remain == CW'(1))  phase = PH_LAST;
        else                        phase = PH_HELD;
    end

    assign slot_free = (phase != PH_HELD);
    assign busy      = (phase != PH_OPEN);

    // R2
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);

endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched
    import wis_pkg::*;
#(
    parameter  int NUM_WARPS    = DEF_WARPS,
    parameter  int ISSUE_CYCLES = DEF_ISSUE_CYCLES,
    localparam int WID_W        = id_width(NUM_WARPS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_WARPS-1:0] inst_valid,
    input  logic [NUM_WARPS-1:0] inst_is_load,
    input  logic [NUM_WARPS-1:0] opnd_rdy,
    input  logic                 ld_ret_valid,
    input  logic [WID_W-1:0]     ld_ret_warp,
    output logic                 issue_o,
    output logic [WID_W-1:0]     issue_warp_o,
    output logic                 busy_o,
    output logic                 stall_o
);

    logic [NUM_WARPS-1:0] eligible;
    logic                 grant_valid;
    logic [WID_W-1:0]     grant_id;
    logic                 slot_free;
    logic                 issue_go;

    wis_scoreboard #(.NW(NUM_WARPS), .IDW(WID_W)) u_sb (
        .clk        (clk),
        .rst        (rst),
        .inst_valid (inst_valid),
        .opnd_rdy   (opnd_rdy),
        .set_en     (issue_go && inst_is_load[grant_id]),
        .set_id     (grant_id),
        .clr_en     (ld_ret_valid),
        .clr_id     (ld_ret_warp),
        .eligible   (eligible)
    );

    wis_rr_pick #(.NW(NUM_WARPS), .IDW(WID_W)) u_pick (
        .clk         (clk),
        .rst         (rst),
        .req         (eligible),
        .take        (issue_go),
        .grant_valid (grant_valid),
        .grant_id    (grant_id)
    );

    wis_slot_timer #(.ISSUE_CYCLES(ISSUE_CYCLES)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .start     (issue_go),
        .slot_free (slot_free),
        .busy      (busy_o)
    );

    assign issue_go = slot_free & grant_valid;
    assign stall_o  = slot_free & ~grant_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_o      <= 1'b0;
            issue_warp_o <= '0;
        end else begin
            issue_o <= issue_go;
            if (issue_go) issue_warp_o <= grant_id;
        end
    end

    // Input-side record and gap counter, kept for the checks below only
    logic [NUM_WARPS-1:0] ready_seen;
    int                   since_issue;

    always_ff @(posedge clk) begin
        if (rst) begin
            ready_seen  <= '0;
            since_issue <= ISSUE_CYCLES;
        end else begin
            ready_seen <= inst_valid & opnd_rdy;
            if (issue_o)                         since_issue <= 1;
            else if (since_issue < ISSUE_CYCLES) since_issue <= since_issue + 1;
        end
    end

    // R1
    issue_ready_chk: assert property (@(posedge clk) disable iff (rst)
        issue_o |-> ready_seen[issue_warp_o]);

    // R2
    issue_gap_chk: assert property (@(posedge clk) disable iff (rst)
        issue_o |-> (since_issue >= ISSUE_CYCLES));

    // R2
    issue_busy_chk: assert property (@(posedge clk) disable iff (rst)
        issue_o |-> busy_o);

    // R6
    stall_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        stall_o |=> !issue_o);

endmodule

// File: tb/sim_warp_issue_sched.sv
module sim_warp_issue_sched;

    localparam int NW  = 16;
    localparam int IC  = 4;
    localparam int IDW = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic [NW-1:0]  inst_valid;
    logic [NW-1:0]  inst_is_load;
    logic [NW-1:0]  opnd_rdy;
    logic           ld_ret_valid;
    logic [IDW-1:0] ld_ret_warp;
    logic           issue_o;
    logic [IDW-1:0] issue_warp_o;
    logic           busy_o;
    logic           stall_o;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    warp_issue_sched #(.NUM_WARPS(NW), .ISSUE_CYCLES(IC)) u0 (
        .clk          (clk),
        .rst          (rst),
        .inst_valid   (inst_valid),
        .inst_is_load (inst_is_load),
        .opnd_rdy     (opnd_rdy),
        .ld_ret_valid (ld_ret_valid),
        .ld_ret_warp  (ld_ret_warp),
        .issue_o      (issue_o),
        .issue_warp_o (issue_warp_o),
        .busy_o       (busy_o),
        .stall_o      (stall_o)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic wait_issue(output int waited);
        waited = 0;
        do begin
            step();
            waited++;
        end while (!issue_o && waited < 64);
    endtask

    task automatic do_reset();
        rst          = 1'b1;
        inst_valid   = '0;
        inst_is_load = '0;
        opnd_rdy     = '0;
        ld_ret_valid = 1'b0;
        ld_ret_warp  = '0;
        repeat (3) step();
    endtask

    task automatic t_reset();
        do_reset();
        chk("R7", "issue_o in reset", int'(issue_o), 0);
        chk("R7", "busy_o in reset", int'(busy_o), 0);
        chk("R7", "issue_warp_o in reset", int'(issue_warp_o), 0);
        rst = 1'b0;
        step();
        chk("R7", "issue_o after reset, no warps", int'(issue_o), 0);
        chk("R7", "busy_o after reset", int'(busy_o), 0);
    endtask

    task automatic t_rotate();
        int w;
        do_reset();
        inst_valid = '1;
        opnd_rdy   = '1;
        rst        = 1'b0;
        for (int n = 0; n < 18; n++) begin
            wait_issue(w);
            chk("R4", "rotation order id", int'(issue_warp_o), n % NW);
            if (n > 0) chk("R3", "cycles between issues", w, IC);
        end
    endtask

    task automatic t_window();
        int w;
        do_reset();
        inst_valid[5] = 1'b1;
        opnd_rdy      = '1;
        rst           = 1'b0;
        wait_issue(w);
        chk("R8", "issued id", int'(issue_warp_o), 5);
        chk("R2", "busy_o on pulse cycle", int'(busy_o), 1);
        for (int k = 1; k < IC; k++) begin
            step();
            chk("R2", "busy_o inside window", int'(busy_o), 1);
            chk("R2", "no pulse inside window", int'(issue_o), 0);
            chk("R8", "id held inside window", int'(issue_warp_o), 5);
        end
        inst_valid = '0;
        step();
        chk("R2", "busy_o after window", int'(busy_o), 0);
        chk("R6", "stall_o after window, nothing valid", int'(stall_o), 1);
        chk("R8", "id held after window", int'(issue_warp_o), 5);
    endtask

    task automatic t_mask();
        int w;
        int exp_seq[4] = '{3, 12, 3, 12};
        do_reset();
        inst_valid[3]  = 1'b1;
        inst_valid[9]  = 1'b1;
        inst_valid[12] = 1'b1;
        opnd_rdy       = '1;
        opnd_rdy[9]    = 1'b0;
        rst            = 1'b0;
        for (int n = 0; n < 4; n++) begin
            wait_issue(w);
            chk("R1", "only ready and valid warps issue", int'(issue_warp_o), exp_seq[n]);
        end
    endtask

    task automatic t_load();
        int w;
        do_reset();
        inst_valid[7]   = 1'b1;
        inst_is_load[7] = 1'b1;
        opnd_rdy        = '1;
        rst             = 1'b0;
        wait_issue(w);
        chk("R5", "load warp issued", int'(issue_warp_o), 7);
        for (int k = 0; k < 10; k++) begin
            step();
            chk("R5", "no reissue while load waits", int'(issue_o), 0);
        end
        chk("R6", "stall_o while only warp waits", int'(stall_o), 1);
        ld_ret_valid = 1'b1;
        ld_ret_warp  = 4'd2;
        step();
        ld_ret_valid = 1'b0;
        for (int k = 0; k < 6; k++) begin
            step();
            chk("R5", "other id return leaves warp blocked", int'(issue_o), 0);
        end
        ld_ret_valid = 1'b1;
        ld_ret_warp  = 4'd7;
        step();
        ld_ret_valid = 1'b0;
        chk("R5", "no issue on return edge", int'(issue_o), 0);
        step();
        chk("R5", "issue one cycle after return", int'(issue_o), 1);
        chk("R5", "reissued id", int'(issue_warp_o), 7);
    endtask

    task automatic t_stall();
        do_reset();
        rst = 1'b0;
        for (int k = 0; k < 3; k++) begin
            step();
            chk("R6", "stall_o with no valid warp", int'(stall_o), 1);
            chk("R6", "no issue with no valid warp", int'(issue_o), 0);
        end
        inst_valid[0] = 1'b1;
        step();
        chk("R6", "stall_o with valid but unready warp", int'(stall_o), 1);
        chk("R1", "unready warp not issued", int'(issue_o), 0);
        opnd_rdy[0] = 1'b1;
        step();
        chk("R1", "ready warp issued", int'(issue_o), 1);
        chk("R6", "stall_o low while slot held", int'(stall_o), 0);
    endtask

    initial begin
        rst          = 1'b1;
        inst_valid   = '0;
        inst_is_load = '0;
        opnd_rdy     = '0;
        ld_ret_valid = 1'b0;
        ld_ret_warp  = '0;
        #1;
        t_reset();
        t_rotate();
        t_window();
        t_mask();
        t_load();
        t_stall();
        if (!done) begin
            done = 1'b1;
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule